// File: doc/BRIEF.md
# SPI pin function multiplexer

This block sits between an SPI shifter and the four pads the shifter may borrow from a general-purpose port. For each pad it decides whether the SPI or the port owns it. When the SPI owns a pad, the block also picks the pad's direction and the value it drives. In the other direction it routes the pad levels back to the shifter as received data, clock and select. Six static control bits choose the arrangement: enable, master, single-wire, shared-line output enable, fault-detect enable and select-output enable.

In master mode the select pad can guard against a second master on the bus. A low level on that pad is brought into the clock domain through a synchronizer and sets a sticky mode-fault flag. While the flag is set, every pad the SPI owns stops driving. Software removes the flag with a one-cycle clear pulse. The shift register and the bit-rate divider live elsewhere. The busy input from the shifter frames the select output.

Top module: `spi_pin_mux`

## Requirements
- R1: Pad bit positions are 0 = clock, 1 = master-out data, 2 = master-in data, 3 = select. With `en` low, every pad copies `gpio_o`/`gpio_oe`. In that state `sh_din` and `sh_sck_in` are 0 and `sh_ss_n` is 1.
- R2: When enabled, the clock pad belongs to the SPI. A master drives `sh_sck` on it and returns `sh_sck` on `sh_sck_in`. A slave leaves the pad undriven and returns the pad level on `sh_sck_in`.
- R3: Master with single-wire off: pad 1 drives `sh_dout`, pad 2 is an input, and `sh_din` follows pad 2.
- R4: Slave with single-wire off: pad 1 is an input that `sh_din` follows, and pad 2 drives `sh_dout`.
- R5: Master with single-wire on: pad 1 is the shared line. It drives `sh_dout` when `bidir_oe` is 1 and is an input when `bidir_oe` is 0, and `sh_din` follows pad 1. Pad 2 returns to the port.
- R6: Slave with single-wire on: pad 2 is the shared line, gated by `bidir_oe` and followed by `sh_din`. Pad 1 returns to the port.
- R7: In slave mode the select pad is an undriven input and `sh_ss_n` follows its level (active low).
- R8: Master with `fault_en` 0: the select pad returns to the port and `sh_ss_n` is 1.
- R9: Master with `fault_en` 1 and `ss_out_en` 1: the select pad drives the inverse of `busy` (low during a transfer).
- R10: Master with `fault_en` 1 and `ss_out_en` 0: the select pad is an input. A low level on it sets `fault` after the third rising clock edge (two synchronizer stages, then the flag). A high level leaves `fault` clear.
- R11: `fault` is sticky and is cleared by a one-cycle `fault_clr`. If a low select level is still being detected in the same cycle, setting wins over clearing. Reset clears the flag.
- R12: While `fault` is set, every pad owned by the SPI has its output enable forced to 0. Pads owned by the port keep `gpio_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | SPI enable |
| master | input | 1 | 1 = master, 0 = slave |
| one_wire | input | 1 | Single-wire shared data line select |
| bidir_oe | input | 1 | Output enable for the shared data line |
| fault_en | input | 1 | Master use of the select pad |
| ss_out_en | input | 1 | Select pad as output (1) or fault input (0) |
| sh_dout | input | 1 | Transmit bit from the shifter |
| sh_sck | input | 1 | Master serial clock from the shifter |
| busy | input | 1 | Transfer in progress |
| fault_clr | input | 1 | One-cycle clear of the mode-fault flag |
| gpio_o | input | 4 | Port output values |
| gpio_oe | input | 4 | Port output enables |
| pin_i | input | 4 | Pad input levels |
| pin_o | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |
| sh_din | output | 1 | Received data bit to the shifter |
| sh_sck_in | output | 1 | Clock seen by the shifter |
| sh_ss_n | output | 1 | Select seen by the shifter, active low |
| fault | output | 1 | Sticky mode-fault flag |

## Verification
The clear pulse and a fresh fault detection can land on the same clock edge. The bench provokes this by holding the select pad low until the flag sets, then pulsing `fault_clr` while the synchronized low is still present. The flag must stay set. The bench then releases the pad, waits for the synchronizer to drain, and pulses the clear again, which must now take effect. The forced-off output enables are judged in the same run, against a port-owned pad whose enable must survive the fault.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

    localparam int PIN_COUNT = 4;
    localparam int PIN_SCK   = 0;
    localparam int PIN_MOSI  = 1;
    localparam int PIN_MISO  = 2;
    localparam int PIN_SS    = 3;

    // Per-pad decision made by the router
    typedef struct packed {
        logic own;    // SPI owns the pad
        logic drive;  // SPI wants to drive it
        logic val;    // value when driving
    } pin_ctl_t;

endpackage

// File: rtl/spi_mode_fault.sv
module spi_mode_fault #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ss_pad,
    input  logic clr,
    output logic flag
);

    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic          flag;
    } mf_state_t;

    mf_state_t st_d, st_q;
    logic      detect;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SW-2:0], ss_pad};
        detect    = arm & ~st_q.sync[SW-1];
        st_d.flag = detect | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R11
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R10
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(arm));

    // R11
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !(arm && !st_q.sync[SW-1])) |=> !flag);

endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route
    import spi_pin_pkg::*;
(
    input  logic                 en,
    input  logic                 master,
    input  logic                 one_wire,
    input  logic                 bidir_oe,
    input  logic                 fault_en,
    input  logic                 ss_out_en,
    input  logic                 sh_dout,
    input  logic                 sh_sck,
    input  logic                 busy,
    input  logic                 fault,
    input  logic [PIN_COUNT-1:0] gpio_o,
    input  logic [PIN_COUNT-1:0] gpio_oe,
    input  logic [PIN_COUNT-1:0] pin_i,
    output logic [PIN_COUNT-1:0] pin_o,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 sh_din,
    output logic                 sh_sck_in,
    output logic                 sh_ss_n
);

    pin_ctl_t ctl [PIN_COUNT];

    always_comb begin
        for (int i = 0; i < PIN_COUNT; i++) ctl[i] = '0;
        sh_din    = 1'b0;
        sh_sck_in = 1'b0;
        sh_ss_n   = 1'b1;
        if (en) begin
            ctl[PIN_SCK] = '{own: 1'b1, drive: master, val: sh_sck};
            sh_sck_in    = master ? sh_sck : pin_i[PIN_SCK];
            if (!one_wire) begin
                ctl[PIN_MOSI] = '{own: 1'b1, drive: master,  val: sh_dout};
                ctl[PIN_MISO] = '{own: 1'b1, drive: ~master, val: sh_dout};
                sh_din        = master ? pin_i[PIN_MISO] : pin_i[PIN_MOSI];
            end else if (master) begin
                ctl[PIN_MOSI] = '{own: 1'b1, drive: bidir_oe, val: sh_dout};
                sh_din        = pin_i[PIN_MOSI];
            end else begin
                ctl[PIN_MISO] = '{own: 1'b1, drive: bidir_oe, val: sh_dout};
                sh_din        = pin_i[PIN_MISO];
            end
            if (!master) begin
                ctl[PIN_SS] = '{own: 1'b1, drive: 1'b0, val: 1'b1};
                sh_ss_n     = pin_i[PIN_SS];
            end else if (fault_en) begin
                ctl[PIN_SS] = '{own: 1'b1, drive: ss_out_en, val: ~busy};
            end
        end
    end

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pad
        assign pin_o[g]  = ctl[g].own ? ctl[g].val : gpio_o[g];
        assign pin_oe[g] = ctl[g].own ? (ctl[g].drive & ~fault) : gpio_oe[g];
    end

endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
    import spi_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       master,
    input  logic       one_wire,
    input  logic       bidir_oe,
    input  logic       fault_en,
    input  logic       ss_out_en,
    input  logic       sh_dout,
    input  logic       sh_sck,
    input  logic       busy,
    input  logic       fault_clr,
    input  logic [3:0] gpio_o,
    input  logic [3:0] gpio_oe,
    input  logic [3:0] pin_i,
    output logic [3:0] pin_o,
    output logic [3:0] pin_oe,
    output logic       sh_din,
    output logic       sh_sck_in,
    output logic       sh_ss_n,
    output logic       fault
);

    logic fault_arm;
    assign fault_arm = en & master & fault_en & ~ss_out_en;

    spi_mode_fault #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (fault_arm),
        .ss_pad (pin_i[PIN_SS]),
        .clr    (fault_clr),
        .flag   (fault)
    );

    spi_pin_route u_route (
        .en        (en),
        .master    (master),
        .one_wire  (one_wire),
        .bidir_oe  (bidir_oe),
        .fault_en  (fault_en),
        .ss_out_en (ss_out_en),
        .sh_dout   (sh_dout),
        .sh_sck    (sh_sck),
        .busy      (busy),
        .fault     (fault),
        .gpio_o    (gpio_o),
        .gpio_oe   (gpio_oe),
        .pin_i     (pin_i),
        .pin_o     (pin_o),
        .pin_oe    (pin_oe),
        .sh_din    (sh_din),
        .sh_sck_in (sh_sck_in),
        .sh_ss_n   (sh_ss_n)
    );

    // R1
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pin_oe == gpio_oe && pin_o == gpio_o && sh_ss_n));

    // R12
    fault_gag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fault) |-> !pin_oe[PIN_SCK]);

    // R9
    ss_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && fault_en && ss_out_en && !fault)
            |-> (pin_oe[PIN_SS] && pin_o[PIN_SS] == !busy));

endmodule

// File: tb/spi_pin_mux_tb_top.sv
module spi_pin_mux_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, master = 0, one_wire = 0, bidir_oe = 0, fault_en = 0, ss_out_en = 0;
    logic sh_dout = 0, sh_sck = 0, busy = 0, fault_clr = 0;
    logic [3:0] gpio_o = 4'b1010, gpio_oe = 4'b0110, pin_i = 4'b1000;
    logic [3:0] pin_o, pin_oe;
    logic sh_din, sh_sck_in, sh_ss_n, fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pin_mux dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .one_wire(one_wire),
        .bidir_oe(bidir_oe), .fault_en(fault_en), .ss_out_en(ss_out_en),
        .sh_dout(sh_dout), .sh_sck(sh_sck), .busy(busy), .fault_clr(fault_clr),
        .gpio_o(gpio_o), .gpio_oe(gpio_oe), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .sh_din(sh_din), .sh_sck_in(sh_sck_in),
        .sh_ss_n(sh_ss_n), .fault(fault)
    );

    typedef struct {
        string      tag;
        logic [3:0] o, oe;
        logic       din, sckin, ssn, flt;
    } exp_t;

    exp_t sb[$];
    int   checks = 0, fails = 0;
    bit   fault_exp = 0;
    bit   done = 0;

    // Reference built from the requirement list
    function automatic exp_t model(string tag);
        exp_t e;
        e.tag = tag; e.o = gpio_o; e.oe = gpio_oe;
        e.din = 0; e.sckin = 0; e.ssn = 1; e.flt = fault_exp;
        if (en) begin
            e.o[0] = sh_sck; e.oe[0] = master;                 // R2
            e.sckin = master ? sh_sck : pin_i[0];
            case ({master, one_wire})
                2'b10: begin e.o[1] = sh_dout; e.oe[1] = 1; e.oe[2] = 0; e.din = pin_i[2]; end // R3
                2'b00: begin e.oe[1] = 0; e.o[2] = sh_dout; e.oe[2] = 1; e.din = pin_i[1]; end // R4
                2'b11: begin e.o[1] = sh_dout; e.oe[1] = bidir_oe; e.din = pin_i[1]; end      // R5
                default: begin e.o[2] = sh_dout; e.oe[2] = bidir_oe; e.din = pin_i[2]; end    // R6
            endcase
            if (!master) begin e.oe[3] = 0; e.ssn = pin_i[3]; end                  // R7
            else if (fault_en) begin e.oe[3] = ss_out_en; e.o[3] = !busy; end      // R9
            if (fault_exp) begin                                                   // R12
                e.oe[0] = 0;
                if (!one_wire || master) e.oe[1] = 0;
                if (!one_wire || !master) e.oe[2] = 0;
                if (!master || fault_en) e.oe[3] = 0;
            end
        end
        return e;
    endfunction

    task automatic push(string tag);
        #1;
        sb.push_back(model(tag));
        wait (sb.size() == 0);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() > 0);
            e = sb[0];
            checks++;
            if (pin_oe !== e.oe || (pin_o & e.oe) !== (e.o & e.oe) || sh_din !== e.din ||
                sh_sck_in !== e.sckin || sh_ss_n !== e.ssn || fault !== e.flt) begin
                fails++;
                $display("FAIL %s: got oe=%b o=%b din=%b sck=%b ssn=%b flt=%b exp oe=%b o=%b din=%b sck=%b ssn=%b flt=%b",
                         e.tag, pin_oe, pin_o & e.oe, sh_din, sh_sck_in, sh_ss_n, fault,
                         e.oe, e.o & e.oe, e.din, e.sckin, e.ssn, e.flt);
            end
            void'(sb.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(); push("R1 reset state");
        tick(); rst_n = 1;
        tick(); gpio_o = 4'b0101; gpio_oe = 4'b1001; pin_i = 4'b1111; push("R1 disabled");
        // master, two-wire
        tick(); en = 1; master = 1; sh_dout = 1; sh_sck = 1; pin_i = 4'b1000; push("R2 R3 master");
        tick(); sh_dout = 0; sh_sck = 0; pin_i = 4'b1100; push("R3 master rx");
        // slave, two-wire
        tick(); master = 0; sh_dout = 1; pin_i = 4'b0011; push("R2 R4 R7 slave");
        tick(); pin_i = 4'b1000; push("R4 R7 slave ss high");
        // single-wire
        tick(); master = 1; one_wire = 1; bidir_oe = 1; gpio_oe = 4'b0100; pin_i = 4'b1010; push("R5 drive");
        tick(); bidir_oe = 0; pin_i = 4'b1000; push("R5 input");
        tick(); master = 0; bidir_oe = 1; gpio_oe = 4'b0010; pin_i = 4'b1100; push("R6 drive");
        tick(); bidir_oe = 0; pin_i = 4'b0110; push("R6 input");
        // master select pad uses
        tick(); master = 1; one_wire = 0; fault_en = 0; gpio_oe = 4'b1000; gpio_o = 4'b1000; pin_i = 4'b1000; push("R8 gpio");
        tick(); fault_en = 1; ss_out_en = 1; busy = 0; push("R9 idle");
        tick(); busy = 1; push("R9 busy");
        // fault input
        tick(); busy = 0; ss_out_en = 0; push("R10 high no fault");
        tick(); push("R10 high no fault");
        tick(); pin_i[3] = 0; push("R10 low edge0");
        tick(); push("R10 low edge1");
        tick(); push("R10 low edge2");
        tick(); fault_exp = 1; push("R10 low edge3");
        tick(); pin_i[3] = 1;
        tick(); push("R11 sticky");
        tick(); one_wire = 1; gpio_oe = 4'b0100; push("R12 gag");
        tick(); one_wire = 0; fault_clr = 1;
        tick(); fault_clr = 0; fault_exp = 0; push("R11 clear");
        // collision: clear while still detecting
        tick(); pin_i[3] = 0;
        tick(); tick(); tick(); fault_exp = 1; push("R10 set again");
        fault_clr = 1;
        tick(); fault_clr = 0; push("R11 set wins");
        pin_i[3] = 1;
        tick(); tick(); tick(); push("R11 still set");
        fault_clr = 1;
        tick(); fault_clr = 0; fault_exp = 0; push("R11 clear after drain");
        tick(); en = 0; push("R1 disabled again");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule